// File: doc/BRIEF.md
# Branch Trace Packet Recorder

This block turns a processor's change-of-flow events into 64-bit trace packets and writes them, one per transfer, into a circular trace region inside shared system RAM. Each packet holds a source address word and a destination address word. An ordinary taken branch yields one packet. An exception return yields two packets that carry the exception return code, so a debugger can later rebuild the program flow from the RAM image.

Software places the trace region anywhere in RAM by giving a base address and a power-of-two size. It then loads the write pointer from the base. Watchpoint logic starts and stops recording with single-cycle trigger pulses. The trace path writes to RAM and never reads from it. The current write pointer and a sticky wrap flag are visible as plain outputs.

Both data interfaces are valid/ready. An event transfers on a clock edge where `ev_valid` and `ev_ready` are both high. The block lowers `ev_ready` only while its one-entry holding queue is occupied and cannot drain. A RAM write transfers on an edge where `mem_valid` and `mem_ready` are both high. While `mem_valid` is high and `mem_ready` is low, the address and data stay frozen.

Top module: `trc_branch_recorder`

## Requirements
- R1: A branch packet is one 64-bit write. Bits [31:0] are the source word {src[31:1], A} and bits [63:32] are the destination word {dst[31:1], 1'b0}. An ordinary branch has A = 0.
- R2: An exception-return event (`ev_exc` = 1, with `ev_src` = instruction address, `ev_dst` = return code and `ev_resume` = resume address) produces two packets back to back. The first packet has source = ev_src, destination = the return code and A = 0. The second has source = the return code, destination = the resume address and A = 1.
- R3: An event that arrives while the second exception packet is pending is held in a one-entry queue. `ev_ready` goes low only while that queue is full and cannot drain. No event is lost and packet order follows event order.
- R4: While `mem_valid` is high and `mem_ready` is low, `mem_valid` stays high and `mem_addr` and `mem_wdata` stay unchanged.
- R5: `mem_addr` equals `wr_ptr`. Each completed write advances the pointer by 8. When the pointer would reach base + size, it returns to base and the pointer stays 8-byte aligned.
- R6: `wrap_flag` sets on the wrapping write and stays set until `cfg_load`. `cfg_load` sets `wr_ptr` to `cfg_base` and clears `wrap_flag` on the next edge.
- R7: The region size is 2^`cfg_size_log2` bytes. A value below 4 is treated as 4 (16 bytes, two packets).
- R8: `trig_start` enables recording from the next cycle and `trig_stop` disables it; stop wins when both are high. Events accepted while not recording are discarded: no write is made and the pointer does not move.
- R9: With the RAM port idle and ready, an event accepted at edge N shows `mem_valid` high after edge N+1 and not before.
- R10: After reset `mem_valid` = 0, `ev_ready` = 1, `wr_ptr` = 0, `wrap_flag` = 0, and recording is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | 32 | Trace region base, aligned to the region size |
| cfg_size_log2 | input | 5 | log2 of region size in bytes (minimum 4) |
| cfg_load | input | 1 | Pulse: pointer to base, clear wrap flag |
| trig_start | input | 1 | Pulse from watchpoint logic: start recording |
| trig_stop | input | 1 | Pulse from watchpoint logic: stop recording |
| ev_valid | input | 1 | Change-of-flow event valid |
| ev_ready | output | 1 | Event accepted on this edge when valid |
| ev_exc | input | 1 | Event is an exception return |
| ev_src | input | 32 | Source instruction address |
| ev_dst | input | 32 | Branch target, or return code for an exception return |
| ev_resume | input | 32 | Resume address (exception return only) |
| mem_valid | output | 1 | RAM write request |
| mem_ready | input | 1 | RAM accepts the write |
| mem_addr | output | 32 | Byte address of the 64-bit write |
| mem_wdata | output | 64 | Packet: source word low, destination word high |
| wr_ptr | output | 32 | Current write pointer |
| wrap_flag | output | 1 | Sticky: the region has wrapped |

## Verification
An event reaches the holding queue one edge after acceptance and the RAM port one edge later. The second exception packet follows on the first edge after the first packet transfers. Pointer and wrap updates land on the edge of the completing write, and `cfg_load` takes effect on the next edge. The bench drives inputs just after falling edges and samples outputs a little later in the low phase. It checks the latency directly right after the accepting edge and one edge later. A scoreboard pops each write when the sample shows valid and ready together, so results are compared against the edge that actually completes them.

// File: rtl/trc_rec_pkg.sv
package trc_rec_pkg;
  localparam int unsigned TRC_AW  = 32;
  localparam int unsigned TRC_SZW = 5;
  localparam int unsigned TRC_PW  = 2 * TRC_AW;

  typedef struct packed {
    logic              is_exc;
    logic [TRC_AW-1:0] src;
    logic [TRC_AW-1:0] dst;
    logic [TRC_AW-1:0] resume;
  } trc_event_t;

  // destination word in the upper half, source word in the lower half
  typedef struct packed {
    logic [TRC_AW-1:0] dst_w;
    logic [TRC_AW-1:0] src_w;
  } trc_pkt_t;

  function automatic logic [TRC_AW-1:0] trc_word(input logic [TRC_AW-1:0] addr,
                                                 input logic flag);
    return {addr[TRC_AW-1:1], flag};
  endfunction
endpackage

// File: rtl/trc_rec_ctrl.sv
module trc_rec_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_start,
  input  logic trig_stop,
  output logic recording
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          recording <= 1'b0;
    else if (trig_stop)  recording <= 1'b0;
    else if (trig_start) recording <= 1'b1;
  end

  assert_stop_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_stop |=> !recording);
  assert_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_start && !trig_stop) |=> recording);
endmodule

// File: rtl/trc_pkt_builder.sv
module trc_pkt_builder
  import trc_rec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       recording,
  input  logic       ev_valid,
  output logic       ev_ready,
  input  trc_event_t ev,
  output logic       pkt_valid,
  input  logic       pkt_ready,
  output trc_pkt_t   pkt
);
  logic              q_valid;
  trc_event_t        q_ev;
  logic              pend2;
  logic [TRC_AW-1:0] pend_code;
  logic [TRC_AW-1:0] pend_res;
  logic              out_valid;
  trc_pkt_t          out_pkt;

  logic out_free, q_drain, ev_take;

  always_comb begin
    out_free = !out_valid || pkt_ready;
    q_drain  = q_valid && out_free && !pend2;
    ev_ready = !q_valid || q_drain;
    ev_take  = ev_valid && ev_ready && recording;
  end

  // output slot: second exception packet has priority over the queue
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pkt   <= '0;
      pend2     <= 1'b0;
      pend_code <= '0;
      pend_res  <= '0;
    end else if (out_free) begin
      if (pend2) begin
        out_valid     <= 1'b1;
        out_pkt.src_w <= trc_word(pend_code, 1'b1);
        out_pkt.dst_w <= trc_word(pend_res, 1'b0);
        pend2         <= 1'b0;
      end else if (q_valid) begin
        out_valid     <= 1'b1;
        out_pkt.src_w <= trc_word(q_ev.src, 1'b0);
        out_pkt.dst_w <= trc_word(q_ev.dst, 1'b0);
        pend2         <= q_ev.is_exc;
        pend_code     <= q_ev.dst;
        pend_res      <= q_ev.resume;
      end else begin
        out_valid <= 1'b0;
      end
    end
  end

  // one-entry holding queue
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_ev    <= '0;
    end else begin
      if (q_drain) q_valid <= 1'b0;
      if (ev_take) begin
        q_valid <= 1'b1;
        q_ev    <= ev;
      end
    end
  end

  assign pkt_valid = out_valid;
  assign pkt       = out_pkt;

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt)));
  assert_pend_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pend2 |-> out_valid);
  assert_second_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_ready && pend2) |=> (pkt_valid && pkt.src_w[0]));
  assert_no_loss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_drain) |=> q_valid);
endmodule

// File: rtl/trc_wr_ptr.sv
module trc_wr_ptr
  import trc_rec_pkg::*;
#(
  parameter int unsigned MIN_LOG2 = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TRC_AW-1:0]  cfg_base,
  input  logic [TRC_SZW-1:0] cfg_size_log2,
  input  logic               cfg_load,
  input  logic               adv,
  output logic [TRC_AW-1:0]  wr_ptr,
  output logic               wrapped
);
  localparam int unsigned PKT_BYTES = TRC_PW / 8;
  localparam int unsigned MAX_LOG2  = TRC_AW - 1;

  logic [TRC_SZW-1:0] eff_log2;
  logic [TRC_AW-1:0]  mask, step, offs, nxt;
  logic               hit;

  always_comb begin
    eff_log2 = cfg_size_log2;
    if (eff_log2 < TRC_SZW'(MIN_LOG2)) eff_log2 = TRC_SZW'(MIN_LOG2);
    if (int'(eff_log2) > MAX_LOG2)     eff_log2 = TRC_SZW'(MAX_LOG2);
    mask = ~({TRC_AW{1'b1}} << eff_log2);
    step = wr_ptr + TRC_AW'(PKT_BYTES);
    offs = step & mask;
    hit  = (offs == '0);
    nxt  = (wr_ptr & ~mask) | offs;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      wrapped <= 1'b0;
    end else if (cfg_load) begin
      wr_ptr  <= cfg_base & ~mask;
      wrapped <= 1'b0;
    end else if (adv) begin
      wr_ptr <= nxt;
      if (hit) wrapped <= 1'b1;
    end
  end

  assert_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr[2:0] == 3'b000);
  assert_wrap_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !cfg_load && hit) |=> wrapped);
  assert_wrap_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrapped && !cfg_load) |=> wrapped);
  assert_load_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> !wrapped);
endmodule

// File: rtl/trc_branch_recorder.sv
module trc_branch_recorder
  import trc_rec_pkg::*;
#(
  parameter int unsigned MIN_LOG2 = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TRC_AW-1:0]  cfg_base,
  input  logic [TRC_SZW-1:0] cfg_size_log2,
  input  logic               cfg_load,
  input  logic               trig_start,
  input  logic               trig_stop,
  input  logic               ev_valid,
  output logic               ev_ready,
  input  logic               ev_exc,
  input  logic [TRC_AW-1:0]  ev_src,
  input  logic [TRC_AW-1:0]  ev_dst,
  input  logic [TRC_AW-1:0]  ev_resume,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic [TRC_AW-1:0]  mem_addr,
  output logic [TRC_PW-1:0]  mem_wdata,
  output logic [TRC_AW-1:0]  wr_ptr,
  output logic               wrap_flag
);
  logic       recording;
  trc_event_t ev;
  trc_pkt_t   pkt;

  assign ev = '{is_exc: ev_exc, src: ev_src, dst: ev_dst, resume: ev_resume};

  trc_rec_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_start(trig_start),
    .trig_stop (trig_stop),
    .recording (recording)
  );

  trc_pkt_builder u_build (
    .clk      (clk),
    .rst_n    (rst_n),
    .recording(recording),
    .ev_valid (ev_valid),
    .ev_ready (ev_ready),
    .ev       (ev),
    .pkt_valid(mem_valid),
    .pkt_ready(mem_ready),
    .pkt      (pkt)
  );

  trc_wr_ptr #(.MIN_LOG2(MIN_LOG2)) u_ptr (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_base     (cfg_base),
    .cfg_size_log2(cfg_size_log2),
    .cfg_load     (cfg_load),
    .adv          (mem_valid && mem_ready),
    .wr_ptr       (wr_ptr),
    .wrapped      (wrap_flag)
  );

  assign mem_addr  = wr_ptr;
  assign mem_wdata = pkt;

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !cfg_load) |=> $stable(mem_addr));
endmodule

// File: tb/trc_branch_recorder_tb.sv
module trc_branch_recorder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [4:0]  cfg_size_log2 = 5'd4;
  logic        cfg_load = 1'b0, trig_start = 1'b0, trig_stop = 1'b0;
  logic        ev_valid = 1'b0, ev_exc = 1'b0;
  logic [31:0] ev_src = '0, ev_dst = '0, ev_resume = '0;
  logic        ev_ready, mem_valid, wrap_flag;
  logic        mem_ready = 1'b1;
  logic [31:0] mem_addr, wr_ptr;
  logic [63:0] mem_wdata;

  int checks = 0, bad = 0, cyc = 0;
  int rdy_mode = 0;
  logic [31:0] qa[$];
  logic [63:0] qd[$];
  bit   m_rec = 0, m_wrap = 0;
  logic [31:0] m_ptr = '0;
  int   m_log2 = 4;

  always #4 clk = ~clk;

  trc_branch_recorder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_size_log2(cfg_size_log2),
    .cfg_load(cfg_load), .trig_start(trig_start), .trig_stop(trig_stop),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_exc(ev_exc), .ev_src(ev_src),
    .ev_dst(ev_dst), .ev_resume(ev_resume), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .wr_ptr(wr_ptr), .wrap_flag(wrap_flag));

  always @(negedge clk) begin
    case (rdy_mode)
      0: mem_ready <= 1'b1;
      1: mem_ready <= ~mem_ready;
      default: mem_ready <= 1'b0;
    endcase
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void push(input logic [31:0] sw, input logic [31:0] dw);
    logic [31:0] mask, step;
    qa.push_back(m_ptr);
    qd.push_back({dw, sw});
    mask = (32'd1 << m_log2) - 1;
    step = (m_ptr + 32'd8) & mask;
    if (step == 0) m_wrap = 1;
    m_ptr = (m_ptr & ~mask) | step;
  endfunction

  // driver: presents one event, waits for acceptance, records expectations
  task automatic send(input bit exc, input logic [31:0] s, input logic [31:0] d,
                      input logic [31:0] r);
    @(negedge clk); #1;
    ev_valid = 1; ev_exc = exc; ev_src = s; ev_dst = d; ev_resume = r;
    while (!ev_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    if (m_rec) begin
      push({s[31:1], 1'b0}, {d[31:1], 1'b0});
      if (exc) push({d[31:1], 1'b1}, {r[31:1], 1'b0});
    end
    #1 ev_valid = 0;
  endtask

  task automatic cfg(input logic [31:0] b, input logic [4:0] l);
    @(negedge clk); #1;
    cfg_base = b; cfg_size_log2 = l; cfg_load = 1;
    @(negedge clk); #1 cfg_load = 0;
    m_ptr = b; m_wrap = 0; m_log2 = (l < 4) ? 4 : int'(l);
  endtask

  task automatic pulse_start();
    @(negedge clk); #1 trig_start = 1;
    @(negedge clk); #1 trig_start = 0;
    m_rec = 1;
  endtask

  task automatic pulse_stop();
    @(negedge clk); #1 trig_stop = 1;
    @(negedge clk); #1 trig_stop = 0;
    m_rec = 0;
  endtask

  task automatic drain();
    int n = 0;
    while ((qa.size() != 0 || mem_valid) && n < 200) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
    #3;
  endtask

  // monitor: scoreboard compare and back-pressure hold check
  bit          p_stall = 0;
  logic [31:0] p_addr;
  logic [63:0] p_data;
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n) begin
        if (p_stall) begin
          chk(mem_valid && mem_addr == p_addr && mem_wdata == p_data, "R4",
              "stalled write changed", mem_wdata, p_data);
        end
        p_stall = mem_valid && !mem_ready;
        p_addr = mem_addr; p_data = mem_wdata;
        if (mem_valid && mem_ready) begin
          if (qa.size() == 0) begin
            chk(0, "R8", "unexpected write", mem_wdata, 64'h0);
          end else begin
            logic [31:0] ea;
            logic [63:0] ed;
            ea = qa.pop_front(); ed = qd.pop_front();
            chk(mem_addr == ea, "R5", "write address", {32'h0, mem_addr}, {32'h0, ea});
            chk(mem_wdata == ed, "R1 R2 R3", "packet", mem_wdata, ed);
          end
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        chk(0, "R0", "watchdog expired", 64'(cyc), 64'h0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] hold_ptr;
    repeat (3) @(negedge clk);
    #3;
    // R10 reset state
    chk(mem_valid == 0, "R10", "mem_valid", 64'(mem_valid), 0);
    chk(ev_ready == 1, "R10", "ev_ready", 64'(ev_ready), 1);
    chk(wr_ptr == 0 && wrap_flag == 0, "R10", "ptr/wrap", {wrap_flag, wr_ptr}, 0);
    #1 rst_n = 1;

    cfg(32'h2000_0100, 5'd5);
    #3 chk(wr_ptr == 32'h2000_0100, "R6", "load sets base", 64'(wr_ptr), 64'h2000_0100);

    // R8: not recording yet, event dropped
    hold_ptr = wr_ptr;
    send(0, 32'h0000_1000, 32'h0000_2000, 0);
    repeat (4) @(negedge clk);
    #3 chk(!mem_valid && wr_ptr == hold_ptr, "R8", "idle drop", 64'(wr_ptr), 64'(hold_ptr));

    pulse_start();
    // R9 latency with port ready
    send(0, 32'h0000_1235, 32'h0000_4441, 0);
    chk(mem_valid == 0, "R9", "early valid", 64'(mem_valid), 0);
    @(posedge clk); #1;
    chk(mem_valid == 1, "R9", "valid after N+1", 64'(mem_valid), 1);
    drain();

    // R2 exception return, then branch right behind (R3)
    send(1, 32'h0000_0A10, 32'hFFFF_FFF9, 32'h0000_0C21);
    send(0, 32'h0000_0C40, 32'h0000_0D00, 0);
    drain();

    // R3 queue full under stall: ev_ready must drop
    rdy_mode = 2;
    send(1, 32'h0000_1110, 32'hFFFF_FFF1, 32'h0000_2220);
    send(0, 32'h0000_3330, 32'h0000_4440, 0);
    @(negedge clk); #3;
    chk(ev_ready == 0, "R3", "ready while queue full", 64'(ev_ready), 0);
    chk(mem_valid == 1, "R4", "valid held under stall", 64'(mem_valid), 1);
    rdy_mode = 1;
    drain();

    // R5 R6 wrap in 4-packet region under toggling ready
    for (int i = 0; i < 5; i++) send(0, 32'h100 + 32'(i * 16), 32'h800 + 32'(i * 4), 0);
    drain();
    chk(wr_ptr == m_ptr, "R5", "pointer after wrap", 64'(wr_ptr), 64'(m_ptr));
    chk(wrap_flag == 1 && m_wrap, "R6", "wrap flag set", 64'(wrap_flag), 1);
    repeat (3) @(negedge clk);
    #3 chk(wrap_flag == 1, "R6", "wrap sticky", 64'(wrap_flag), 1);
    rdy_mode = 0;

    // R7 size clamp: log2=2 acts as 16 bytes
    cfg(32'h3000_0040, 5'd2);
    #3 chk(wrap_flag == 0, "R6", "load clears wrap", 64'(wrap_flag), 0);
    send(0, 32'h0000_5000, 32'h0000_6000, 0);
    send(0, 32'h0000_5010, 32'h0000_6010, 0);
    drain();
    chk(wr_ptr == 32'h3000_0040, "R7", "16-byte region wraps", 64'(wr_ptr), 64'h3000_0040);
    chk(wrap_flag == 1, "R7", "wrap after two packets", 64'(wrap_flag), 1);

    // R8 stop then event dropped
    pulse_stop();
    hold_ptr = wr_ptr;
    send(1, 32'h0000_7000, 32'hFFFF_FFF9, 32'h0000_7100);
    repeat (5) @(negedge clk);
    #3 chk(!mem_valid && wr_ptr == hold_ptr, "R8", "stopped drop", 64'(wr_ptr), 64'(hold_ptr));
    chk(qa.size() == 0, "R3", "all expected writes seen", 64'(qa.size()), 0);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule